// File: doc/BRIEF.md
# Dual-Channel DAC Update Sequencer

This block sits between a 32-bit control/status word and two DAC channels. Software sets a command bit in the word to ask a channel for an output update or an output clear. The bit stays readable as one while the command waits. It drops by itself when the channel's sequencer takes the command. The sequencer captures the channel's present span and output value and sends them to the device as a one-cycle request with an operation code. It waits for the device's acknowledge, brought in through a two-flop synchronizer. It then holds a settling pulse of fixed length before it goes idle again.

Each channel reports its own status in its own byte of the word. Busy is the OR of four conditions. Output-settle shows the settling pulse. Over-temperature is the synchronized device flag. A span written to the range input but not yet sent to the device keeps busy high until an update or clear carries it over. A command that arrives while the channel is working is held and runs once the current sequence ends.

Top module: `dac_seq_ctrl`

## Requirements
- R1: After reset every bit of the status word reads 0 and no device request is raised.
- R2: Channel 1 uses byte bits 7:0 and channel 2 uses bits 15:8 with the same layout: bit 0 busy, bit 1 settle, bit 3 over-temperature, bit 4 clear command, bit 5 update command. Bits 2, 6, 7, 10 and 31:14 always read 0. Writing ones to reserved or status-only bits changes nothing.
- R3: Writing 1 to a channel's update bit (bit 5 or 13) makes it read 1 until the idle channel takes it on the next clock. In that cycle it drops, and a one-cycle device request follows with op 0 (update), carrying the span and value inputs as they stood when the command was taken.
- R4: Writing 1 to a channel's clear bit (bit 4 or 12) behaves the same way but issues the request with op 1 (clear). The request also carries the span and value.
- R5: If clear and update are both pending, the clear runs first. The update stays pending and runs as the next sequence.
- R6: A command written while its channel is not idle is held pending and runs after the current sequence. A set that lands in the same cycle the channel takes a command stays pending. Writing 0 has no effect.
- R7: The sequence advances on a rising edge of the acknowledge after two synchronizer flops. The settle bit first reads 1 three cycles after the cycle in which the acknowledge input rises.
- R8: The settle bit stays high for exactly round(20.5e-6 x CLK_HZ) cycles, which is 2563 at 125 MHz. The channel is idle on the cycle after.
- R9: Busy reads 1 when any of these holds: the sequencer is not idle, a span change is untransferred, a command is pending, or a synchronizer stage disagrees with the next.
- R10: The over-temperature bit follows the device flag input, delayed by two clocks.
- R11: A span input that differs from the span last sent to the device holds busy at 1 until a sequence transfers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control/status word |
| span_in | input | NUM_CH*SPAN_W | Per-channel span setting to transfer |
| value_in | input | NUM_CH*DATA_W | Per-channel output value to transfer |
| dev_req | output | NUM_CH | One-cycle request to each device |
| dev_op | output | NUM_CH | Operation code per channel, 0 update, 1 clear |
| dev_span | output | NUM_CH*SPAN_W | Span captured for the request |
| dev_data | output | NUM_CH*DATA_W | Value captured for the request |
| dev_ack | input | NUM_CH | Asynchronous acknowledge from each device |
| dev_ovrtmp | input | NUM_CH | Asynchronous over-temperature flag from each device |

## Verification
Two things can fall on one clock edge. A new command bit can be set on the same edge the sequencer takes or finishes a command. Clear and update can also be written in one cycle. The bench provokes the first case by writing an update on the last settling cycle, which its model identifies. The bit must then read 1 on the next cycle and a fresh request must follow. For the second case it writes both bits together and expects a clear request first and an update request next. A cycle-accurate model in the bench judges every field of the word and every request on each clock.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_REQ    = 2'd1,
      SEQ_WAIT   = 2'd2,
      SEQ_SETTLE = 2'd3
   } seq_state_e;

   localparam int unsigned FIELD_W  = 8;
   localparam int unsigned B_BUSY   = 0;
   localparam int unsigned B_SETTLE = 1;
   localparam int unsigned B_OVR    = 3;
   localparam int unsigned B_CLR    = 4;
   localparam int unsigned B_UPD    = 5;

   localparam logic OP_UPDATE = 1'b0;
   localparam logic OP_CLEAR  = 1'b1;

   // round(20.5 us * hz), half rounds up
   function automatic int unsigned settle_cycles(input longint unsigned hz);
      longint unsigned prod;
      prod = hz * 64'd205 + 64'd5_000_000;
      return 32'(prod / 64'd10_000_000);
   endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] moving
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dac_sync needs at least two stages");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dac_sync width must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

   always_comb begin
      moving = '0;
      for (int i = 1; i < STAGES; i++) moving = moving | (stg[i] ^ stg[i-1]);
   end

endmodule

// File: rtl/dac_settle_tmr.sv
module dac_settle_tmr #(
   parameter int unsigned CYC = 2563
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic done
);

   localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC - 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("settle length must be at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (start) begin
         cnt <= LOAD;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign active = run;
   assign done   = run && (cnt == '0);

   assert_settle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !done) |=> active);
   assert_settle_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(done));
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active);

endmodule

// File: rtl/dac_chan_seq.sv
module dac_chan_seq
   import dac_seq_pkg::*;
#(
   parameter int unsigned SPAN_W     = 3,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned SETTLE_CYC = 2563
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_upd_set,
   input  logic              cmd_clr_set,
   input  logic [SPAN_W-1:0] span_in,
   input  logic [DATA_W-1:0] value_in,
   input  logic              ack_rise,
   output logic              dev_req,
   output logic              dev_op,
   output logic [SPAN_W-1:0] dev_span,
   output logic [DATA_W-1:0] dev_data,
   output logic              pend_upd,
   output logic              pend_clr,
   output logic              active,
   output logic              settling,
   output logic              span_dirty
);

   seq_state_e        state;
   logic [SPAN_W-1:0] sent_span;
   logic              accept, take_clr, take_upd;
   logic              tmr_start, tmr_done;

   assign accept   = (state == SEQ_IDLE) && (pend_clr || pend_upd);
   assign take_clr = accept && pend_clr;
   assign take_upd = accept && !pend_clr && pend_upd;
   assign tmr_start = (state == SEQ_WAIT) && ack_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_clr <= 1'b0;
         pend_upd <= 1'b0;
      end else begin
         pend_clr <= (pend_clr && !take_clr) || cmd_clr_set;
         pend_upd <= (pend_upd && !take_upd) || cmd_upd_set;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         dev_op    <= OP_UPDATE;
         dev_span  <= '0;
         dev_data  <= '0;
         sent_span <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: if (accept) begin
               state     <= SEQ_REQ;
               dev_op    <= take_clr ? OP_CLEAR : OP_UPDATE;
               dev_span  <= span_in;
               dev_data  <= value_in;
               sent_span <= span_in;
            end
            SEQ_REQ:    state <= SEQ_WAIT;
            SEQ_WAIT:   if (ack_rise) state <= SEQ_SETTLE;
            SEQ_SETTLE: if (tmr_done) state <= SEQ_IDLE;
            default:    state <= SEQ_IDLE;
         endcase
      end
   end

   dac_settle_tmr #(.CYC(SETTLE_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .active (settling),
      .done   (tmr_done)
   );

   assign dev_req    = (state == SEQ_REQ);
   assign active     = (state != SEQ_IDLE);
   assign span_dirty = (span_in != sent_span);

   assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req |=> !dev_req);
   assert_clear_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && pend_clr) |=> (dev_req && dev_op == OP_CLEAR));
   assert_hold_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && pend_upd) |=> pend_upd);
   assert_ack_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_WAIT && !ack_rise) |=> (state == SEQ_WAIT));
   assert_settle_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_SETTLE) |-> settling);

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
   import dac_seq_pkg::*;
#(
   parameter int unsigned      NUM_CH      = 2,
   parameter int unsigned      SPAN_W      = 3,
   parameter int unsigned      DATA_W      = 16,
   parameter longint unsigned  CLK_HZ      = 125_000_000,
   parameter int unsigned      SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   input  logic [NUM_CH*SPAN_W-1:0] span_in,
   input  logic [NUM_CH*DATA_W-1:0] value_in,
   output logic [NUM_CH-1:0]        dev_req,
   output logic [NUM_CH-1:0]        dev_op,
   output logic [NUM_CH*SPAN_W-1:0] dev_span,
   output logic [NUM_CH*DATA_W-1:0] dev_data,
   input  logic [NUM_CH-1:0]        dev_ack,
   input  logic [NUM_CH-1:0]        dev_ovrtmp
);

   localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ);
   localparam int unsigned SYNC_W     = 2 * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH * FIELD_W > 32) begin : g_bad_ch
         $error("channel count does not fit the 32-bit word");
      end
      if (SPAN_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("span and data widths must be positive");
      end
   endgenerate

   logic [SYNC_W-1:0] sync_q, sync_mv;
   logic [NUM_CH-1:0] ack_q, ack_d, ack_rise, ovr_q;
   logic [NUM_CH-1:0][FIELD_W-1:0] field;

   dac_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({dev_ovrtmp, dev_ack}),
      .q      (sync_q),
      .moving (sync_mv)
   );

   assign ack_q = sync_q[NUM_CH-1:0];
   assign ovr_q = sync_q[SYNC_W-1:NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_d <= '0;
      else        ack_d <= ack_q;
   end

   assign ack_rise = ack_q & ~ack_d;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int unsigned BASE = c * FIELD_W;
         logic p_upd, p_clr, act, stl, dirty, busy;

         dac_chan_seq #(
            .SPAN_W     (SPAN_W),
            .DATA_W     (DATA_W),
            .SETTLE_CYC (SETTLE_CYC)
         ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_upd_set (reg_wr && reg_wdata[BASE + B_UPD]),
            .cmd_clr_set (reg_wr && reg_wdata[BASE + B_CLR]),
            .span_in     (span_in[c*SPAN_W +: SPAN_W]),
            .value_in    (value_in[c*DATA_W +: DATA_W]),
            .ack_rise    (ack_rise[c]),
            .dev_req     (dev_req[c]),
            .dev_op      (dev_op[c]),
            .dev_span    (dev_span[c*SPAN_W +: SPAN_W]),
            .dev_data    (dev_data[c*DATA_W +: DATA_W]),
            .pend_upd    (p_upd),
            .pend_clr    (p_clr),
            .active      (act),
            .settling    (stl),
            .span_dirty  (dirty)
         );

         assign busy = act || dirty || p_upd || p_clr
                       || sync_mv[c] || sync_mv[NUM_CH + c];

         always_comb begin
            field[c]           = '0;
            field[c][B_BUSY]   = busy;
            field[c][B_SETTLE] = stl;
            field[c][B_OVR]    = ovr_q[c];
            field[c][B_CLR]    = p_clr;
            field[c][B_UPD]    = p_upd;
         end

         assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_rdata[BASE + B_BUSY] |-> !dev_req[c]);
         assert_settle_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
            reg_rdata[BASE + B_SETTLE] |-> reg_rdata[BASE + B_BUSY]);
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) reg_rdata[c*FIELD_W +: FIELD_W] = field[c];
   end

   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   assert_ovr_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && SYNC_STAGES == 2) |-> (ovr_q == $past(dev_ovrtmp, 2)));
   assert_req_onehot_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_req) |-> (|$past(reg_rdata)));

endmodule

// File: tb/test_dac_seq_ctrl.sv
module test_dac_seq_ctrl;
   localparam int NCH = 2, SW = 3, DW = 16;
   localparam int SC  = 2563;
   localparam logic [31:0] RES_MASK = 32'hFFFF_C4C4;

   logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH*SW-1:0] span_in = '0;
   logic [NCH*DW-1:0] value_in = '0;
   logic [NCH-1:0] dev_req, dev_op, dev_ack = '0, dev_ovrtmp = '0;
   logic [NCH*SW-1:0] dev_span;
   logic [NCH*DW-1:0] dev_data;

   always #4 clk = ~clk;

   dac_seq_ctrl i_dac_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .span_in(span_in), .value_in(value_in),
      .dev_req(dev_req), .dev_op(dev_op), .dev_span(dev_span),
      .dev_data(dev_data), .dev_ack(dev_ack), .dev_ovrtmp(dev_ovrtmp)
   );

   int vectors = 0, errors = 0;

   // behavioural reference, one slot per channel
   int m_st[NCH], m_cnt[NCH], m_pu[NCH], m_pc[NCH], m_op[NCH];
   int m_span[NCH], m_data[NCH], m_sent[NCH];
   int m_a1[NCH], m_a2[NCH], m_a3[NCH], m_o1[NCH], m_o2[NCH];

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (!rst_n) begin
            m_st[c] = 0; m_cnt[c] = 0; m_pu[c] = 0; m_pc[c] = 0; m_op[c] = 0;
            m_span[c] = 0; m_data[c] = 0; m_sent[c] = 0;
            m_a1[c] = 0; m_a2[c] = 0; m_a3[c] = 0; m_o1[c] = 0; m_o2[c] = 0;
         end else begin
            int rise;
            rise = (m_a2[c] == 1 && m_a3[c] == 0);
            m_a3[c] = m_a2[c]; m_a2[c] = m_a1[c]; m_a1[c] = int'(dev_ack[c]);
            m_o2[c] = m_o1[c]; m_o1[c] = int'(dev_ovrtmp[c]);
            case (m_st[c])
               0: if (m_pc[c] != 0 || m_pu[c] != 0) begin
                     m_op[c] = (m_pc[c] != 0) ? 1 : 0;
                     if (m_pc[c] != 0) m_pc[c] = 0; else m_pu[c] = 0;
                     m_span[c] = int'(span_in[c*SW +: SW]);
                     m_data[c] = int'(value_in[c*DW +: DW]);
                     m_sent[c] = m_span[c];
                     m_st[c] = 1;
                  end
               1: m_st[c] = 2;
               2: if (rise != 0) begin m_st[c] = 3; m_cnt[c] = SC; end
               default: begin
                  m_cnt[c] = m_cnt[c] - 1;
                  if (m_cnt[c] == 0) m_st[c] = 0;
               end
            endcase
            if (reg_wr && reg_wdata[c*8 + 4]) m_pc[c] = 1;
            if (reg_wr && reg_wdata[c*8 + 5]) m_pu[c] = 1;
         end
      end
   end

   function automatic logic [31:0] exp_word();
      logic [31:0] w = '0;
      for (int c = 0; c < NCH; c++) begin
         w[c*8 + 0] = (m_st[c] != 0) || (int'(span_in[c*SW +: SW]) != m_sent[c])
                      || (m_pu[c] != 0) || (m_pc[c] != 0)
                      || (m_a1[c] != m_a2[c]) || (m_o1[c] != m_o2[c]);
         w[c*8 + 1] = (m_st[c] == 3);
         w[c*8 + 3] = (m_o2[c] != 0);
         w[c*8 + 4] = (m_pc[c] != 0);
         w[c*8 + 5] = (m_pu[c] != 0);
      end
      return w;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   bit finished = 0;

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [31:0] e;
         e = exp_word();
         for (int c = 0; c < NCH; c++) begin
            check("R9",  "busy",    32'(reg_rdata[c*8+0]), 32'(e[c*8+0]));
            check("R8",  "settle",  32'(reg_rdata[c*8+1]), 32'(e[c*8+1]));
            check("R10", "ovrtmp",  32'(reg_rdata[c*8+3]), 32'(e[c*8+3]));
            check("R4",  "clr bit", 32'(reg_rdata[c*8+4]), 32'(e[c*8+4]));
            check("R3",  "upd bit", 32'(reg_rdata[c*8+5]), 32'(e[c*8+5]));
            check("R3",  "dev_req", 32'(dev_req[c]), 32'(m_st[c] == 1));
            if (m_st[c] == 1) begin
               check("R4", "dev_op",   32'(dev_op[c]), 32'(m_op[c]));
               check("R3", "dev_span", 32'(dev_span[c*SW +: SW]), 32'(m_span[c]));
               check("R3", "dev_data", 32'(dev_data[c*DW +: DW]), 32'(m_data[c]));
            end
         end
         check("R2", "reserved", reg_rdata & RES_MASK, 32'h0);
      end
   end

   // device responder: one-cycle acknowledge a fixed delay after each request
   int ack_cd[NCH];
   int ack_dly[NCH] = '{3, 5};
   always @(negedge clk) begin
      #1;
      for (int c = 0; c < NCH; c++) begin
         dev_ack[c] = 1'b0;
         if (ack_cd[c] > 0) begin
            ack_cd[c]--;
            if (ack_cd[c] == 0) dev_ack[c] = 1'b1;
         end
         if (dev_req[c]) ack_cd[c] = ack_dly[c];
      end
   end

   task automatic step(bit wr = 1'b0, logic [31:0] d = '0);
      @(negedge clk);
      #2;
      reg_wr    = wr;
      reg_wdata = d;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 20000; n++) begin
         if (m_st[0] == 0 && m_st[1] == 0 && m_pu[0] == 0 && m_pu[1] == 0
             && m_pc[0] == 0 && m_pc[1] == 0) break;
         step();
      end
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) step();
      @(negedge clk); rst_n = 1'b1;
      step();
      check("R1", "word after reset", reg_rdata, 32'h0);
      check("R1", "req after reset", 32'(dev_req), 32'h0);

      // R2: ones into reserved and status-only bits, then a zero write
      step(1'b1, RES_MASK | 32'h0000_0B0B);
      step(1'b1, 32'h0);
      step(); step();
      check("R2", "word after reserved writes", reg_rdata, 32'h0);

      // R11: a fresh span marks the channel busy
      span_in[0 +: SW] = 3'd5; value_in[0 +: DW] = 16'h1234;
      step();
      check("R11", "span dirty busy", 32'(reg_rdata[0]), 32'd1);

      // R3: update on channel 1
      step(1'b1, 32'h0000_0020);
      step();
      check("R3", "update bit pending", 32'(reg_rdata[5]), 32'd1);
      step();
      check("R3", "update request", 32'(dev_req[0]), 32'd1);
      check("R3", "update op", 32'(dev_op[0]), 32'd0);
      check("R3", "update span", 32'(dev_span[0 +: SW]), 32'd5);
      check("R3", "update value", 32'(dev_data[0 +: DW]), 32'h1234);
      check("R3", "update bit self-cleared", 32'(reg_rdata[5]), 32'd0);

      // R7: ack to settle latency
      n = 0;
      while (!reg_rdata[1] && n < 50) begin step(); n++; end
      check("R7", "req to settle cycles", 32'(n), 32'(ack_dly[0] + 3));

      // R8: settle length
      n = 0;
      while (reg_rdata[1] && n < SC + 10) begin n++; step(); end
      check("R8", "settle length", 32'(n), 32'(SC));
      check("R9", "busy after sequence", 32'(reg_rdata[0]), 32'd0);

      // R4: clear on channel 2
      span_in[SW +: SW] = 3'd2; value_in[DW +: DW] = 16'hBEEF;
      step(1'b1, 32'h0000_1000);
      step();
      check("R4", "clear bit pending", 32'(reg_rdata[12]), 32'd1);
      step();
      check("R4", "clear request", 32'(dev_req[1]), 32'd1);
      check("R4", "clear op", 32'(dev_op[1]), 32'd1);
      wait_idle();

      // R5: clear and update together
      value_in[0 +: DW] = 16'h0F0F;
      step(1'b1, 32'h0000_0030);
      step(); step();
      check("R5", "first request is clear", 32'({dev_req[0], dev_op[0]}), 32'b11);
      check("R5", "update still pending", 32'(reg_rdata[5]), 32'd1);
      n = 0;
      step();
      while (!dev_req[0] && n < 6000) begin step(); n++; end
      check("R5", "second request is update", 32'({dev_req[0], dev_op[0]}), 32'b10);
      wait_idle();

      // R6: command written while settling is held
      step(1'b1, 32'h0000_0020);
      n = 0;
      while (!reg_rdata[1] && n < 50) begin step(); n++; end
      step(1'b1, 32'h0000_0020);
      step();
      check("R6", "held while busy", 32'({reg_rdata[5], dev_req[0]}), 32'b10);
      n = 0;
      while (!dev_req[0] && n < 6000) begin step(); n++; end
      check("R6", "held command runs", 32'(dev_req[0]), 32'd1);
      wait_idle();

      // R6: set on the final settling cycle
      step(1'b1, 32'h0000_2000);
      n = 0;
      while (!(m_st[1] == 3 && m_cnt[1] == 1) && n < 6000) begin step(); n++; end
      step(1'b1, 32'h0000_2000);
      step();
      check("R6", "set on last settle cycle", 32'({reg_rdata[13], reg_rdata[9]}), 32'b10);
      step();
      check("R6", "request after last-cycle set", 32'(dev_req[1]), 32'd1);
      wait_idle();

      // both channels in one write
      step(1'b1, 32'h0000_2020);
      wait_idle();

      // R10: over-temperature through the synchronizer
      dev_ovrtmp[0] = 1'b1;
      step();
      check("R9", "busy while flag in flight", 32'(reg_rdata[0]), 32'd1);
      check("R10", "flag after one clock", 32'(reg_rdata[3]), 32'd0);
      step();
      check("R10", "flag after two clocks", 32'(reg_rdata[3]), 32'd1);
      dev_ovrtmp[1] = 1'b1;
      step();
      dev_ovrtmp[1] = 1'b0;
      step(); step(); step();
      check("R10", "pulse passed and gone", 32'(reg_rdata[11]), 32'd0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule